// File: doc/BRIEF.md
# ALU Status Flag Unit

This block generates and holds the low status byte that sits beside a 16-bit integer ALU. On each clock it receives an operation class, the two operands and the result that the datapath produced. From these it updates carry/borrow, digit carry, overflow, negative, zero and a sticky zero flag. The ALU datapath itself lives elsewhere. The current carry goes back to the datapath as a separate output, for multi-word add-with-carry and subtract-with-borrow chains.

The same byte also holds two loop-activity flags, one for a single-instruction repeat and one for a multi-instruction loop. Event strobes from the sequencer drive them. A one-deep shadow copy of the whole byte is saved on a push strobe and written back on a pop strobe. The repeat flag has a private one-bit save slot, taken whenever a repeat starts, so that a repeat begun inside an interrupted repeat hands the outer state back when it ends.

The zero and sticky zero flags behave in a special way across a chain of carry-consuming operations. Neither flag is ever set by such an operation. A nonzero partial word clears both flags. So after the chain, both flags tell whether the complete multi-word result is zero.

Top module: `sf_status_unit`

## Requirements
- R1: After reset the status byte is 0x00 and the carry output is 0. Bit positions in the status byte, from bit 7 down to bit 0, are: loop-active, repeat-active, sticky zero, negative, overflow, zero, digit carry, carry.
- R2: Operation class codes are: 0 neutral, 1 add, 2 subtract, 3 add-with-carry, 4 subtract-with-borrow, 5 logic. Codes 6 and 7 act as neutral. An add (code 1) sets C to the carry out of bit 15, DC to the carry out of bit 3, OV to signed two's-complement overflow, N to result bit 15, and both Z and SZ to (result == 0).
- R3: A subtract (code 2) computes a + ~b + 1 and sets the flags by the same rules as an add. C=1 therefore means no borrow, and C=0 means a borrow occurred.
- R4: Add-with-carry (code 3) and subtract-with-borrow (code 4) use the stored C as carry in and update C, DC, OV and N. A nonzero result clears both Z and SZ. A zero result leaves both Z and SZ unchanged.
- R5: A logic operation (code 5) updates N, Z and SZ (SZ equal to Z) and leaves C, DC and OV unchanged.
- R6: A neutral operation with no strobe asserted leaves the whole status byte unchanged.
- R7: A repeat-start strobe sets the repeat-active bit and copies its previous value into a one-bit save slot. A repeat-end strobe loads the repeat-active bit from that slot.
- R8: A loop-start strobe sets the loop-active bit. A loop-end strobe clears it. If both strobes arrive in the same cycle, start wins.
- R9: A push strobe stores the status byte as it was before that cycle's update. A pop strobe replaces the whole byte, loop bits included, with the stored copy, and this takes priority over any operation or loop event in the same cycle.
- R10: The carry output always equals the stored C bit.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation class code for this cycle |
| opa_i | input | 16 | First operand |
| opb_i | input | 16 | Second operand (subtrahend for subtract classes) |
| res_i | input | 16 | Result produced by the datapath |
| rpt_start_i | input | 1 | Repeat begins |
| rpt_end_i | input | 1 | Repeated instruction finished its last pass |
| do_start_i | input | 1 | First instruction of a loop executes |
| do_end_i | input | 1 | Last loop instruction finished its final pass |
| push_i | input | 1 | Save status byte to the shadow |
| pop_i | input | 1 | Restore status byte from the shadow |
| status_o | output | 8 | Status byte |
| carry_o | output | 1 | Current carry for extended arithmetic |

## Verification
The hardest case to reach is a carry chain in which a later word is zero after an earlier word was nonzero. Here the sticky zero flag must stay clear even though the last result is zero. The stimulus builds explicit two-word sums with exact carries that reach each ordering of zero and nonzero words. A nested repeat start is issued while the repeat flag is already set, and pops are issued in the same cycle as arithmetic, so that the save slot and the restore priority are visible at the status byte. A long mixed random sequence then compares every cycle against a behavioural integer model.

// File: rtl/sf_pkg.sv
package sf_pkg;
   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_ADD   = 3'd1,
      OP_SUB   = 3'd2,
      OP_ADDC  = 3'd3,
      OP_SUBB  = 3'd4,
      OP_LOGIC = 3'd5
   } sf_op_e;

   localparam int BIT_C  = 0;
   localparam int BIT_DC = 1;
   localparam int BIT_Z  = 2;
   localparam int BIT_OV = 3;
   localparam int BIT_N  = 4;
   localparam int BIT_SZ = 5;
   localparam int BIT_RA = 6;
   localparam int BIT_DA = 7;
   localparam int ARITH_BITS = 6;
   localparam int STATUS_W   = 8;
endpackage

// File: rtl/sf_arith_flags.sv
module sf_arith_flags
   import sf_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NIB_W  = 4
) (
   input  logic [2:0]            op_i,
   input  logic [DATA_W-1:0]     a_i,
   input  logic [DATA_W-1:0]     b_i,
   input  logic [DATA_W-1:0]     r_i,
   input  logic [ARITH_BITS-1:0] cur_i,
   output logic [ARITH_BITS-1:0] nxt_o
);
   localparam int MSB = DATA_W - 1;

   logic              is_sub, is_chain, is_arith, is_logic;
   logic [DATA_W-1:0] bx;
   logic [DATA_W-1:0] cin_vec;
   logic              c_out, ov, res_zero;

   always_comb begin
      is_sub   = (op_i == OP_SUB) || (op_i == OP_SUBB);
      is_chain = (op_i == OP_ADDC) || (op_i == OP_SUBB);
      is_arith = (op_i == OP_ADD) || (op_i == OP_SUB) || is_chain;
      is_logic = (op_i == OP_LOGIC);
      bx       = is_sub ? ~b_i : b_i;
   end

   // carry into each bit position, recovered from operands and result
   for (genvar k = 0; k < DATA_W; k++) begin : g_cin
      assign cin_vec[k] = a_i[k] ^ bx[k] ^ r_i[k];
   end

   always_comb begin
      c_out    = (a_i[MSB] & bx[MSB]) | ((a_i[MSB] ^ bx[MSB]) & ~r_i[MSB]);
      ov       = (a_i[MSB] == bx[MSB]) && (r_i[MSB] != a_i[MSB]);
      res_zero = (r_i == '0);
      nxt_o    = cur_i;
      if (is_arith) begin
         nxt_o[BIT_C]  = c_out;
         nxt_o[BIT_DC] = cin_vec[NIB_W];
         nxt_o[BIT_OV] = ov;
         nxt_o[BIT_N]  = r_i[MSB];
         if (is_chain) begin
            if (!res_zero) begin
               nxt_o[BIT_Z]  = 1'b0;
               nxt_o[BIT_SZ] = 1'b0;
            end
         end else begin
            nxt_o[BIT_Z]  = res_zero;
            nxt_o[BIT_SZ] = res_zero;
         end
      end else if (is_logic) begin
         nxt_o[BIT_N]  = r_i[MSB];
         nxt_o[BIT_Z]  = res_zero;
         nxt_o[BIT_SZ] = res_zero;
      end
   end
endmodule

// File: rtl/sf_loop_flags.sv
module sf_loop_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic rpt_start_i,
   input  logic rpt_end_i,
   input  logic do_start_i,
   input  logic do_end_i,
   input  logic restore_i,
   input  logic ra_rst_i,
   input  logic da_rst_i,
   output logic ra_o,
   output logic da_o
);
   logic ra_save_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ra_o      <= 1'b0;
         da_o      <= 1'b0;
         ra_save_q <= 1'b0;
      end else begin
         if (rpt_start_i) ra_save_q <= ra_o;
         if (restore_i) begin
            ra_o <= ra_rst_i;
            da_o <= da_rst_i;
         end else begin
            if (rpt_start_i)    ra_o <= 1'b1;
            else if (rpt_end_i) ra_o <= ra_save_q;
            if (do_start_i)     da_o <= 1'b1;
            else if (do_end_i)  da_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sf_shadow.sv
module sf_shadow #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= '0;
      else if (push_i) q_o <= d_i;
   end
endmodule

// File: rtl/sf_status_unit.sv
module sf_status_unit
   import sf_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NIB_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic              rpt_start_i,
   input  logic              rpt_end_i,
   input  logic              do_start_i,
   input  logic              do_end_i,
   input  logic              push_i,
   input  logic              pop_i,
   output logic [7:0]        status_o,
   output logic              carry_o
);
   if (DATA_W < 8) begin : g_bad_w
      $error("DATA_W must be at least 8");
   end
   if (NIB_W < 1 || NIB_W >= DATA_W) begin : g_bad_nib
      $error("NIB_W must lie inside the data word");
   end

   logic [ARITH_BITS-1:0] arith_q, arith_nxt;
   logic [STATUS_W-1:0]   shadow_q;
   logic                  ra, da;

   sf_arith_flags #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_arith (
      .op_i (op_i),
      .a_i  (opa_i),
      .b_i  (opb_i),
      .r_i  (res_i),
      .cur_i(arith_q),
      .nxt_o(arith_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     arith_q <= '0;
      else if (pop_i) arith_q <= shadow_q[ARITH_BITS-1:0];
      else            arith_q <= arith_nxt;
   end

   sf_loop_flags u_loop (
      .clk        (clk),
      .rst_n      (rst_n),
      .rpt_start_i(rpt_start_i),
      .rpt_end_i  (rpt_end_i),
      .do_start_i (do_start_i),
      .do_end_i   (do_end_i),
      .restore_i  (pop_i),
      .ra_rst_i   (shadow_q[BIT_RA]),
      .da_rst_i   (shadow_q[BIT_DA]),
      .ra_o       (ra),
      .da_o       (da)
   );

   sf_shadow #(.WIDTH(STATUS_W)) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .push_i(push_i),
      .d_i   (status_o),
      .q_o   (shadow_q)
   );

   assign status_o = {da, ra, arith_q};
   assign carry_o  = arith_q[BIT_C];
endmodule

// File: rtl/sf_status_chk.sv
module sf_status_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        op_i,
   input logic [DATA_W-1:0] res_i,
   input logic              rpt_start_i,
   input logic              rpt_end_i,
   input logic              do_start_i,
   input logic              do_end_i,
   input logic              push_i,
   input logic              pop_i,
   input logic [7:0]        status_o,
   input logic [7:0]        shadow_q
);
   // R2: add loads zero flag from the result
   a_r2_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd1 && !pop_i) |=> status_o[2] == ($past(res_i) == '0));

   // R4: chained ops never raise sticky zero
   a_r4_sz_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_i == 3'd3 || op_i == 3'd4) && !pop_i) |=> !$rose(status_o[5]));

   // R6: neutral cycle keeps the byte
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd0 && !pop_i && !rpt_start_i && !rpt_end_i && !do_start_i && !do_end_i)
      |=> $stable(status_o));

   // R7: repeat start raises the repeat bit
   a_r7_rpt_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_start_i && !pop_i) |=> status_o[6]);

   // R8: loop end alone drops the loop bit
   a_r8_do_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (do_end_i && !do_start_i && !pop_i) |=> !status_o[7]);

   // R9: pop restores the saved byte
   a_r9_pop: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |=> status_o == $past(shadow_q));
endmodule

bind sf_status_unit sf_status_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_i       (op_i),
   .res_i      (res_i),
   .rpt_start_i(rpt_start_i),
   .rpt_end_i  (rpt_end_i),
   .do_start_i (do_start_i),
   .do_end_i   (do_end_i),
   .push_i     (push_i),
   .pop_i      (pop_i),
   .status_o   (status_o),
   .shadow_q   (shadow_q)
);

// File: tb/sim_sf_status_unit.sv
module sim_sf_status_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = '0;
   logic [15:0] opa_i = '0, opb_i = '0, res_i = '0;
   logic        rpt_start_i = 0, rpt_end_i = 0, do_start_i = 0, do_end_i = 0;
   logic        push_i = 0, pop_i = 0;
   logic [7:0]  status_o;
   logic        carry_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural model state
   int mC, mDC, mZ, mOV, mN, mSZ, mRA, mDA, mRsave;
   int msh;

   sf_status_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
      .res_i(res_i), .rpt_start_i(rpt_start_i), .rpt_end_i(rpt_end_i),
      .do_start_i(do_start_i), .do_end_i(do_end_i), .push_i(push_i),
      .pop_i(pop_i), .status_o(status_o), .carry_o(carry_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int mbyte();
      return mDA*128 + mRA*64 + mSZ*32 + mN*16 + mOV*8 + mZ*4 + mDC*2 + mC;
   endfunction

   task automatic check(input string tag);
      checks++;
      if (status_o !== 8'(mbyte()) || carry_o !== 1'(mC)) begin
         errors++;
         $display("FAIL %s status=%02h carry=%0d expected status=%02h carry=%0d",
                  tag, status_o, carry_o, mbyte(), mC);
      end
   endtask

   // one clock: compute result and expected flags, drive, compare after edge
   task automatic step(input int op, input int a, input int b,
                       input bit rs, input bit re, input bit ds, input bit de,
                       input bit pu, input bit po, input string tag);
      int bb, cin, sum, sa, sb, s, r, old, nra;
      old = mbyte();
      bb = b; cin = 0;
      if (op == 2 || op == 4) bb = (~b) & 16'hFFFF;
      if (op == 2) cin = 1;
      if (op == 3 || op == 4) cin = mC;
      sum = a + bb + cin;
      r = (op == 5) ? (a & b) : (sum & 16'hFFFF);
      @(negedge clk);
      op_i = 3'(op); opa_i = 16'(a); opb_i = 16'(b); res_i = 16'(r);
      rpt_start_i = rs; rpt_end_i = re; do_start_i = ds; do_end_i = de;
      push_i = pu; pop_i = po;
      @(posedge clk);
      #1;
      if (op >= 1 && op <= 4) begin
         sa = (a >= 32768) ? a - 65536 : a;
         sb = (bb >= 32768) ? bb - 65536 : bb;
         s = sa + sb + cin;
         mC  = (sum >> 16) & 1;
         mDC = (((a & 15) + (bb & 15) + cin) >> 4) & 1;
         mOV = (s > 32767 || s < -32768) ? 1 : 0;
         mN  = (r >> 15) & 1;
         if (op == 1 || op == 2) begin
            mZ = (r == 0); mSZ = mZ;
         end else if (r != 0) begin
            mZ = 0; mSZ = 0;
         end
      end else if (op == 5) begin
         mN = (r >> 15) & 1; mZ = (r == 0); mSZ = mZ;
      end
      nra = mRA;
      if (rs) begin nra = 1; mRsave = mRA; end
      else if (re) nra = mRsave;
      mRA = nra;
      if (ds) mDA = 1; else if (de) mDA = 0;
      if (po) begin
         mC = msh & 1; mDC = (msh >> 1) & 1; mZ = (msh >> 2) & 1; mOV = (msh >> 3) & 1;
         mN = (msh >> 4) & 1; mSZ = (msh >> 5) & 1; mRA = (msh >> 6) & 1; mDA = (msh >> 7) & 1;
      end
      if (pu) msh = old;
      check(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      mC = 0; mDC = 0; mZ = 0; mOV = 0; mN = 0; mSZ = 0; mRA = 0; mDA = 0;
      mRsave = 0; msh = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset");
      // R2 add wrap to zero, then signed overflow
      step(1, 16'hFFFF, 1, 0,0,0,0,0,0, "R2 add wrap");
      step(1, 16'h7FFF, 1, 0,0,0,0,0,0, "R2 add overflow");
      step(1, 16'h0008, 16'h0008, 0,0,0,0,0,0, "R2 digit carry");
      // R3 subtract, no borrow and borrow
      step(2, 5, 3, 0,0,0,0,0,0, "R3 sub no borrow");
      step(2, 3, 5, 0,0,0,0,0,0, "R3 sub borrow");
      step(2, 16'h8000, 1, 0,0,0,0,0,0, "R3 sub overflow");
      // R4 chains: whole-zero, late-zero after nonzero, nonzero high word
      step(1, 16'hFFFF, 1, 0,0,0,0,0,0, "R4 low word zero");
      step(3, 0, 16'hFFFF, 0,0,0,0,0,0, "R4 high word zero with carry");
      step(1, 1, 0, 0,0,0,0,0,0, "R4 low word nonzero");
      step(3, 0, 0, 0,0,0,0,0,0, "R4 zero high word keeps SZ clear");
      step(2, 0, 1, 0,0,0,0,0,0, "R4 sub low borrow");
      step(4, 1, 0, 0,0,0,0,0,0, "R4 subb consumes borrow to zero");
      step(4, 7, 2, 0,0,0,0,0,0, "R4 subb nonzero clears Z");
      // R5 logic keeps C, DC, OV
      step(1, 16'hFFFF, 16'hFFFF, 0,0,0,0,0,0, "R5 setup carry");
      step(5, 16'hF0F0, 16'h0F0F, 0,0,0,0,0,0, "R5 logic zero");
      step(5, 16'h8001, 16'hFFFF, 0,0,0,0,0,0, "R5 logic negative");
      // R6 neutral and unused codes
      step(0, 16'h1234, 16'h4321, 0,0,0,0,0,0, "R6 neutral");
      step(6, 0, 0, 0,0,0,0,0,0, "R6 code 6");
      step(7, 5, 5, 0,0,0,0,0,0, "R6 code 7");
      // R7 repeat, including nested start
      step(0, 0, 0, 1,0,0,0,0,0, "R7 repeat start");
      step(0, 0, 0, 1,0,0,0,0,0, "R7 nested start");
      step(0, 0, 0, 0,1,0,0,0,0, "R7 end restores outer");
      step(0, 0, 0, 0,1,0,0,0,0, "R7 end again");
      // R8 loop flag
      step(0, 0, 0, 0,0,1,0,0,0, "R8 loop start");
      step(0, 0, 0, 0,0,1,1,0,0, "R8 start wins");
      step(0, 0, 0, 0,0,0,1,0,0, "R8 loop end");
      // R9 push, disturb, pop with simultaneous op
      step(1, 16'h7FFF, 1, 0,0,1,0,1,0, "R9 push with loop start");
      step(2, 9, 9, 1,0,0,1,0,0, "R9 disturb");
      step(1, 1, 1, 0,0,0,0,0,1, "R9 pop over add");
      step(0, 0, 0, 0,0,0,0,1,1, "R9 push and pop together");
      step(0, 0, 0, 0,0,0,0,0,1, "R9 pop returns prior byte");
      // R10 carry follows C through a random mix
      for (int i = 0; i < 400; i++) begin
         int op, rr;
         rr = $urandom_range(0, 99);
         op = $urandom_range(0, 7);
         step(op, $urandom_range(0, 65535), $urandom_range(0, 65535),
              rr < 6, rr >= 6 && rr < 12, rr >= 12 && rr < 16, rr >= 16 && rr < 20,
              rr >= 20 && rr < 26, rr >= 26 && rr < 30, "R10 random mix");
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule